// File: doc/BRIEF.md
# Fractional Clock Frequency Synthesizer

This block derives a slower square wave from its input clock. The output frequency is the input frequency divided by twice a fixed-point divisor. The divisor has three integer bits and fourteen fraction bits, so fractional ratios such as 2.333 are available. A phase accumulator adds one unit (2^14) every input cycle. Whenever it reaches the divisor, the divisor is subtracted and the output toggles. Each half-period is therefore either the floor or the ceiling of the divisor, and the long-run average is exact.

A control register holds the divisor in its low 17 bits and can be read back. Software can write the whole register, or write only the divisor field so that the upper bits are kept. A changed divisor is adopted only at the next output toggle, so no half-period is ever cut short. Besides the square wave, a one-cycle strobe marks every rising output edge and can serve as a clock enable for logic in the input clock domain.

Top module: `frac_synth`

## Requirements
- R1: While and after synchronous active-high reset, the output and the strobe are low and the register reads back as zero.
- R2: A full-register write (`reg_wr`) loads all register bits, and `reg_rdata` returns the written value on the following cycle.
- R3: A field write (`fld_wr`) replaces only bits [16:0], the divisor field, and every higher register bit keeps its value. If both strobes are high, the full write wins.
- R4: When the divisor field is zero and no half-period is in progress, the output stays low and no strobe occurs.
- R5: A nonzero divisor field below 16384 (below 1.0) is treated as exactly 1.0, giving one toggle per input cycle.
- R6: The divisor field holds integer bits [16:14] and fraction bits [13:0] (raw = div × 2^14). Over N output periods, the number of input cycles is within ±1 of 2·N·div.
- R7: A divisor written while the output runs takes effect only at the next toggle. The half-period already in progress completes with the old divisor.
- R8: `rise_stb` is high for exactly one cycle, in the same cycle that `synth_out` first reads high after being low, and at no other time.
- R9: Writing a zero divisor while the output runs stops it at the next toggle. From then on the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Full control-register write strobe |
| fld_wr | input | 1 | Divisor-field-only write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control register contents |
| synth_out | output | 1 | Synthesized square wave |
| rise_stb | output | 1 | One-cycle marker of each rising output edge |

## Verification
The assertions assume that reset is held for at least one clock edge before any write, and that write data is stable around the sampling edge. Every divisor value is legal, so nothing else is assumed about the inputs. The stimulus drives all inputs on falling edges and raises reset at time zero. Between tests the bench reaches a known divisor either by a fresh reset or by writing at a known point relative to the strobe, so that the cycle at which each update takes effect is predictable.

// File: rtl/frac_synth_pkg.sv
package frac_synth_pkg;
   localparam int unsigned DEF_REG_W  = 32;
   localparam int unsigned DEF_DIV_W  = 17;
   localparam int unsigned DEF_FRAC_W = 14;

   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;
endpackage

// File: rtl/frac_synth_regs.sv
module frac_synth_regs #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned DIV_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reg_wr,
   input  logic             fld_wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [DIV_W-1:0] div_field
);
   localparam int unsigned UP_W = REG_W - DIV_W;

   initial begin
      a_cfg_widths: assert (REG_W >= DIV_W && DIV_W > 1)
         else $error("register narrower than divisor field");
   end

   logic [DIV_W-1:0] field_q;

   always_ff @(posedge clk) begin
      if (rst)
         field_q <= '0;
      else if (reg_wr || fld_wr)
         field_q <= wdata[DIV_W-1:0];
   end

   assign div_field = field_q;

   generate
      if (UP_W > 0) begin : g_upper
         logic [UP_W-1:0] upper_q;
         always_ff @(posedge clk) begin
            if (rst)
               upper_q <= '0;
            else if (reg_wr)
               upper_q <= wdata[REG_W-1:DIV_W];
         end
         assign rdata = {upper_q, field_q};

         // R3: field-only writes leave the upper bits untouched
         a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
            (fld_wr && !reg_wr) |=> $stable(upper_q));
      end else begin : g_flat
         assign rdata = field_q;
      end
   endgenerate

   // R2: a full write is visible on the next cycle
   a_r2_readback: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> (rdata == $past(wdata)));
endmodule

// File: rtl/frac_synth_core.sv
module frac_synth_core
   import frac_synth_pkg::*;
#(
   parameter int unsigned DIV_W  = 17,
   parameter int unsigned FRAC_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             synth_out,
   output logic             rise_stb
);
   localparam int unsigned ACC_W = DIV_W + 1;
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;

   initial begin
      a_cfg_frac: assert (FRAC_W < DIV_W)
         else $error("fraction must leave at least one integer bit");
   end

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] act_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic             out_q;
   logic             stb_q;
   logic             hit;
   phase_e           phase;

   // clamp: nonzero values under 1.0 become 1.0
   always_comb begin
      if (div_cfg != '0 && div_cfg < ONE)
         div_eff = ONE;
      else
         div_eff = div_cfg;
   end

   assign phase   = (act_q != '0) ? PH_RUN : PH_IDLE;
   assign acc_sum = acc_q + ACC_W'(ONE);
   assign hit     = (phase == PH_RUN) && (acc_sum >= {1'b0, act_q});

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= '0;
         acc_q <= '0;
         out_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (phase == PH_IDLE) begin
            act_q <= div_eff;
            acc_q <= '0;
            out_q <= 1'b0;
         end else if (hit) begin
            act_q <= div_eff;
            if (div_eff == '0) begin
               out_q <= 1'b0;
               acc_q <= '0;
            end else begin
               out_q <= ~out_q;
               stb_q <= ~out_q;
               acc_q <= acc_sum - {1'b0, act_q};
            end
         end else begin
            acc_q <= acc_sum;
         end
      end
   end

   assign synth_out = out_q;
   assign rise_stb  = stb_q;

   // R5: the active divisor is never in the open range (0, 1.0)
   a_r5_clamp: assert property (@(posedge clk) disable iff (rst)
      (act_q == '0) || (act_q >= ONE));

   // R4: an idle synthesizer drives low
   a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
      (act_q == '0) |-> !out_q);

   // R6: accumulator residue stays below the active divisor
   a_r6_acc_bound: assert property (@(posedge clk) disable iff (rst)
      (act_q != '0) |-> (acc_q < {1'b0, act_q}));

   // R7: a running divisor changes only on a toggle
   a_r7_update_on_toggle: assert property (@(posedge clk) disable iff (rst)
      ((act_q != $past(act_q)) && ($past(act_q) != '0)) |-> $past(hit));

   // R8: strobe coincides with a fresh rising edge
   a_r8_strobe_edge: assert property (@(posedge clk) disable iff (rst)
      rise_stb |-> (synth_out && !$past(synth_out)));
endmodule

// File: rtl/frac_synth.sv
module frac_synth
   import frac_synth_pkg::*;
#(
   parameter int unsigned REG_W  = DEF_REG_W,
   parameter int unsigned DIV_W  = DEF_DIV_W,
   parameter int unsigned FRAC_W = DEF_FRAC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reg_wr,
   input  logic             fld_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             synth_out,
   output logic             rise_stb
);
   logic [DIV_W-1:0] div_field;

   frac_synth_regs #(.REG_W(REG_W), .DIV_W(DIV_W)) regs_i (
      .clk       (clk),
      .rst       (rst),
      .reg_wr    (reg_wr),
      .fld_wr    (fld_wr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .div_field (div_field)
   );

   frac_synth_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) core_i (
      .clk       (clk),
      .rst       (rst),
      .div_cfg   (div_field),
      .synth_out (synth_out),
      .rise_stb  (rise_stb)
   );

   // R1: reset leaves the outputs quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!synth_out && !rise_stb && reg_rdata == '0));
endmodule

// File: tb/frac_synth_tb_top.sv
module frac_synth_tb_top;
   localparam int NVEC = 8;
   localparam int NPER = 8;
   localparam logic [16:0] VEC_DIV [NVEC] = '{
      17'd16384, 17'd24576, 17'd32768, 17'd53248,
      17'd38229, 17'd131071, 17'd100, 17'd1
   };
   localparam logic [31:0] FMASK = 32'h0001_FFFF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic        fld_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        synth_out;
   logic        rise_stb;

   int checks = 0;
   int fails  = 0;
   int wd     = 0;

   always #2 clk = ~clk;

   frac_synth dut_i (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .fld_wr(fld_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .synth_out(synth_out), .rise_stb(rise_stb)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   task automatic wr(input bit full, input logic [31:0] d);
      reg_wr = full; fld_wr = !full; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; fld_wr = 1'b0;
   endtask

   task automatic wait_stb(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (rise_stb) begin seen = 1'b1; break; end
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 150000) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit seen;
      int cyc, nst, bad, hi, lo;
      longint raw_eff, diff;
      logic [31:0] prev;

      // R1: reset state
      do_reset();
      @(negedge clk);
      chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
      chk(!synth_out && !rise_stb, "R1 outputs", synth_out, 0);

      // R4: zero divisor after reset stays low
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (synth_out || rise_stb) bad++;
      end
      chk(bad == 0, "R4 idle low", bad, 0);

      // R6 / R5 / R8: table of divisors
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         @(negedge clk);
         wr(1'b0, {15'd0, VEC_DIV[v]});
         wait_stb(seen);
         chk(seen, "R6 start", seen, 1);
         cyc = 0; nst = 0; bad = 0;
         prev = {31'd0, synth_out};
         while (nst < NPER && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (rise_stb != (synth_out && !prev[0])) bad++;
            prev = {31'd0, synth_out};
            if (rise_stb) nst++;
         end
         raw_eff = (VEC_DIV[v] < 17'd16384) ? 16384 : VEC_DIV[v];
         diff = longint'(cyc) * 16384 - 2 * NPER * raw_eff;
         if (diff < 0) diff = -diff;
         chk(diff <= 16384, (VEC_DIV[v] < 17'd16384) ? "R5 clamp period" : "R6 period",
             cyc, (2 * NPER * raw_eff) / 16384);
         chk(bad == 0, "R8 strobe", bad, 0);
      end

      // R2 / R3: register write semantics
      do_reset();
      @(negedge clk);
      wr(1'b1, 32'hA5A5_2345);
      chk(reg_rdata == 32'hA5A5_2345, "R2 full write", reg_rdata, 32'hA5A5_2345);
      wr(1'b0, 32'h5A5A_0ABC);
      chk(reg_rdata == ((32'hA5A5_2345 & ~FMASK) | (32'h5A5A_0ABC & FMASK)),
          "R3 field write", reg_rdata, (32'hA5A5_2345 & ~FMASK) | (32'h5A5A_0ABC & FMASK));
      reg_wr = 1'b1; fld_wr = 1'b1; reg_wdata = 32'h1234_0000;
      @(negedge clk); reg_wr = 1'b0; fld_wr = 1'b0;
      chk(reg_rdata == 32'h1234_0000, "R3 full wins", reg_rdata, 32'h1234_0000);
      // R4: upper bits set, field zero -> still idle
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (synth_out || rise_stb) bad++;
      end
      chk(bad == 0, "R4 field zero", bad, 0);

      // R7: update waits for the next toggle
      do_reset();
      @(negedge clk);
      wr(1'b0, 32'd65536);
      wait_stb(seen);
      wait_stb(seen);
      reg_wdata = 32'd16384; fld_wr = 1'b1;
      hi = 1;
      @(negedge clk); fld_wr = 1'b0;
      while (synth_out && hi < 20) begin hi++; @(negedge clk); end
      chk(hi == 4, "R7 old half-period kept", hi, 4);
      lo = 0;
      while (!synth_out && lo < 20) begin lo++; @(negedge clk); end
      chk(lo == 1, "R7 new divisor used", lo, 1);

      // R9: disable while running
      do_reset();
      @(negedge clk);
      wr(1'b0, 32'd65536);
      wait_stb(seen);
      reg_wdata = 32'd0; fld_wr = 1'b1;
      hi = 1;
      @(negedge clk); fld_wr = 1'b0;
      while (synth_out && hi < 20) begin hi++; @(negedge clk); end
      chk(hi == 4, "R9 finish half-period", hi, 4);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (synth_out || rise_stb) bad++;
      end
      chk(bad == 0, "R9 stays low", bad, 0);

      // R1: reset while running
      wr(1'b1, 32'hFFFF_4000);
      wait_stb(seen);
      rst = 1'b1;
      @(negedge clk);
      chk(!synth_out && reg_rdata == 0, "R1 reset while running", reg_rdata, 0);
      rst = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule